// File: doc/BRIEF.md
# Fill-Mode Word Shifter

A combinational shifter for a 16-bit datapath. It moves a data word left or right by a count read from a general register, then fills the vacated bit positions under one of four policies chosen by a 2-bit mode field. The policies are zero fill, ones fill, a copy of the bit at the vacated edge, and rotation of the bits that leave the word. One operation therefore covers the logical, ones-fill, arithmetic (edge-replicate) and rotate cases in both directions.

The count comes from a full-width register. In rotate mode it is reduced modulo the word width. In the three fill modes, any count equal to or larger than the word width produces a word made entirely of fill bits. A zero flag reports an all-zero result for use by downstream flag logic. The block has no state, so results follow the inputs in the same cycle.

Top module: `fill_shifter`

## Requirements
- R1: `dir_i` = 0 shifts toward the MSB (left). `dir_i` = 1 shifts toward the LSB (right).
- R2: With `mode_i` = 2'b00, every vacated position is 0.
- R3: With `mode_i` = 2'b01, every vacated position is 1. A nonzero count therefore never gives an all-zero result.
- R4: With `mode_i` = 2'b10, vacated positions copy the edge bit being vacated. That is `data_i[15]` for a right shift and `data_i[0]` for a left shift.
- R5: With `mode_i` = 2'b11, bits that leave one end enter at the other, so the number of set bits is preserved.
- R6: A count of 0 returns `data_i` unchanged in every mode and direction.
- R7: In rotate mode only `amt_i[3:0]` matters (count modulo 16). The upper bits of `amt_i` have no effect on `data_o`.
- R8: In modes 2'b00, 2'b01 and 2'b10, a count of 16 or more gives a word in which every bit equals the fill bit of that mode.
- R9: `zero_o` is 1 exactly when `data_o` is all zeros.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| data_i | input | 16 | Operand word to shift |
| amt_i | input | 16 | Shift count, taken from a register |
| dir_i | input | 1 | 0 = left, 1 = right |
| mode_i | input | 2 | 00 zeros, 01 ones, 10 edge copy, 11 rotate |
| data_o | output | 16 | Shifted word |
| zero_o | output | 1 | High when `data_o` is zero |

## Verification
Both outputs are purely combinational, so each result is due in the same cycle that its operands are applied, with no register on the path. The bench drives every operand set on a falling clock edge. It samples `data_o` and `zero_o` a few nanoseconds later, before the next rising edge, so the value read always belongs to the operands just applied. Expected words come from a per-bit reference that shifts one position at a time, plus a hand-computed vector table. The checks cover counts from 0 through 20, so the wrap of 16 and the saturation of 16 are both crossed.

// File: rtl/fill_shift_pkg.sv
package fill_shift_pkg;
  typedef enum logic [1:0] {
    FILL_ZERO = 2'b00,
    FILL_ONE  = 2'b01,
    FILL_EDGE = 2'b10,
    FILL_ROT  = 2'b11
  } fill_mode_e;

  typedef enum logic {
    DIR_LEFT  = 1'b0,
    DIR_RIGHT = 1'b1
  } shift_dir_e;
endpackage

// File: rtl/fs_amt_dec.sv
// Splits a register-wide count into the in-range shift and an overrange flag.
module fs_amt_dec #(
  parameter int AMT_W = 16,
  parameter int SH_W  = 4
) (
  input  logic [AMT_W-1:0] amt_i,
  output logic [SH_W-1:0]  shamt_o,
  output logic             ovf_o
);
  assign shamt_o = amt_i[SH_W-1:0];

  generate
    if (AMT_W > SH_W) begin : g_hi
      assign ovf_o = |amt_i[AMT_W-1:SH_W];
    end else begin : g_no_hi
      assign ovf_o = 1'b0;
    end
  endgenerate
endmodule

// File: rtl/fs_bit_rev.sv
// Optional bit reversal; lets one left-only shifter serve both directions.
module fs_bit_rev #(
  parameter int W = 16
) (
  input  logic         en_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] d_o
);
  logic [W-1:0] rev;

  generate
    for (genvar i = 0; i < W; i++) begin : g_rev
      assign rev[i] = d_i[W-1-i];
    end
  endgenerate

  assign d_o = en_i ? rev : d_i;
endmodule

// File: rtl/fs_fill_sel.sv
module fs_fill_sel
  import fill_shift_pkg::*;
(
  input  fill_mode_e mode_i,
  input  logic       edge_i,
  output logic       fill_o,
  output logic       rot_o
);
  always_comb begin
    rot_o  = 1'b0;
    fill_o = 1'b0;
    unique case (mode_i)
      FILL_ZERO: fill_o = 1'b0;
      FILL_ONE:  fill_o = 1'b1;
      FILL_EDGE: fill_o = edge_i;
      FILL_ROT:  rot_o  = 1'b1;
      default:   fill_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/fs_left_core.sv
// Logarithmic left shifter; stage s moves by 2**s. W must be a power of two.
module fs_left_core #(
  parameter int W    = 16,
  parameter int SH_W = 4
) (
  input  logic [W-1:0]    d_i,
  input  logic [SH_W-1:0] shamt_i,
  input  logic            fill_i,
  input  logic            rot_i,
  output logic [W-1:0]    d_o
);
  logic [SH_W:0][W-1:0] stg;

  assign stg[0] = d_i;

  generate
    for (genvar s = 0; s < SH_W; s++) begin : g_stage
      localparam int N = 1 << s;
      logic [N-1:0] ins;
      assign ins        = rot_i ? stg[s][W-1 -: N] : {N{fill_i}};
      assign stg[s+1]   = shamt_i[s] ? {stg[s][W-N-1:0], ins} : stg[s];
    end
  endgenerate

  assign d_o = stg[SH_W];
endmodule

// File: rtl/fill_shifter.sv
module fill_shifter
  import fill_shift_pkg::*;
#(
  parameter int WIDTH = 16,
  parameter int AMT_W = 16
) (
  input  logic [WIDTH-1:0] data_i,
  input  logic [AMT_W-1:0] amt_i,
  input  logic             dir_i,
  input  logic [1:0]       mode_i,
  output logic [WIDTH-1:0] data_o,
  output logic             zero_o
);
  localparam int SH_W = $clog2(WIDTH);

  logic [SH_W-1:0]  shamt;
  logic             ovf;
  logic [WIDTH-1:0] in_norm;
  logic [WIDTH-1:0] core_out;
  logic [WIDTH-1:0] pre_out;
  logic             fill_bit;
  logic             rot;
  logic             is_right;
  fill_mode_e       mode;

  assign is_right = (dir_i == DIR_RIGHT);
  assign mode     = fill_mode_e'(mode_i);

  fs_amt_dec #(.AMT_W(AMT_W), .SH_W(SH_W)) u_amt (
    .amt_i   (amt_i),
    .shamt_o (shamt),
    .ovf_o   (ovf)
  );

  fs_bit_rev #(.W(WIDTH)) u_rev_in (
    .en_i (is_right),
    .d_i  (data_i),
    .d_o  (in_norm)
  );

  // after normalisation, the vacated edge is always bit 0
  fs_fill_sel u_fill (
    .mode_i (mode),
    .edge_i (in_norm[0]),
    .fill_o (fill_bit),
    .rot_o  (rot)
  );

  fs_left_core #(.W(WIDTH), .SH_W(SH_W)) u_core (
    .d_i     (in_norm),
    .shamt_i (shamt),
    .fill_i  (fill_bit),
    .rot_i   (rot),
    .d_o     (core_out)
  );

  // overrange count saturates fill modes; rotate wraps
  assign pre_out = (ovf && !rot) ? {WIDTH{fill_bit}} : core_out;

  fs_bit_rev #(.W(WIDTH)) u_rev_out (
    .en_i (is_right),
    .d_i  (pre_out),
    .d_o  (data_o)
  );

  assign zero_o = ~|data_o;
endmodule

// File: rtl/fill_shifter_chk.sv
module fill_shifter_chk #(
  parameter int WIDTH = 16,
  parameter int AMT_W = 16
) (
  input logic [WIDTH-1:0] data_i,
  input logic [AMT_W-1:0] amt_i,
  input logic             dir_i,
  input logic [1:0]       mode_i,
  input logic [WIDTH-1:0] data_o,
  input logic             zero_o
);
  always_comb begin
    if (amt_i == '0)
      a_r6_zero_count: assert (data_o == data_i) else $error("R6 zero count altered word");
    if (mode_i == 2'b00 && amt_i >= AMT_W'(WIDTH))
      a_r8_sat_zeros: assert (data_o == '0) else $error("R8 zero-fill saturation");
    if (mode_i == 2'b01 && amt_i >= AMT_W'(WIDTH))
      a_r8_sat_ones: assert (&data_o) else $error("R8 ones-fill saturation");
    if (mode_i == 2'b01 && amt_i != '0)
      a_r3_ones_nonzero: assert (!zero_o) else $error("R3 ones fill gave zero");
    if (mode_i == 2'b11)
      a_r5_rot_popcount: assert ($countones(data_o) == $countones(data_i)) else $error("R5 rotate lost bits");
    if (mode_i == 2'b10 && dir_i && amt_i != '0)
      a_r4_sign_kept: assert (data_o[WIDTH-1] == data_i[WIDTH-1]) else $error("R4 sign not replicated");
    if (mode_i == 2'b00 && !dir_i && amt_i != '0)
      a_r1_left_lsb_clear: assert (!data_o[0]) else $error("R1 left zero fill set bit 0");
  end
endmodule

bind fill_shifter fill_shifter_chk #(.WIDTH(WIDTH), .AMT_W(AMT_W)) u_chk (
  .data_i (data_i),
  .amt_i  (amt_i),
  .dir_i  (dir_i),
  .mode_i (mode_i),
  .data_o (data_o),
  .zero_o (zero_o)
);

// File: tb/fill_shifter_tb_top.sv
`timescale 1ns/1ps
module fill_shifter_tb_top;
  localparam int W  = 16;
  localparam int NV = 18;
  localparam int VW = 16 + 16 + 1 + 2 + 16;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic [W-1:0]  data_i = '0;
  logic [15:0]   amt_i  = '0;
  logic          dir_i  = 1'b0;
  logic [1:0]    mode_i = 2'b00;
  logic [W-1:0]  data_o;
  logic          zero_o;

  int n_run  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  fill_shifter dut_i (
    .data_i (data_i),
    .amt_i  (amt_i),
    .dir_i  (dir_i),
    .mode_i (mode_i),
    .data_o (data_o),
    .zero_o (zero_o)
  );

  // {data, amount, dir, mode, expected}
  localparam logic [VW-1:0] VEC [NV] = '{
    {16'h1234, 16'd4,     1'b0, 2'b00, 16'h2340},  // R1 R2
    {16'h1234, 16'd4,     1'b1, 2'b00, 16'h0123},  // R1 R2
    {16'h1234, 16'd4,     1'b0, 2'b01, 16'h234F},  // R3
    {16'h1234, 16'd4,     1'b1, 2'b01, 16'hF123},  // R3
    {16'h8001, 16'd1,     1'b1, 2'b10, 16'hC000},  // R4
    {16'h8001, 16'd1,     1'b0, 2'b10, 16'h0003},  // R4
    {16'h4000, 16'd3,     1'b1, 2'b10, 16'h0800},  // R4
    {16'h1234, 16'd4,     1'b0, 2'b11, 16'h2341},  // R5
    {16'h1234, 16'd4,     1'b1, 2'b11, 16'h4123},  // R5
    {16'h1234, 16'd20,    1'b0, 2'b11, 16'h2341},  // R7
    {16'hABCD, 16'd16,    1'b0, 2'b00, 16'h0000},  // R8
    {16'hABCD, 16'h0100,  1'b1, 2'b01, 16'hFFFF},  // R8
    {16'h8000, 16'd17,    1'b1, 2'b10, 16'hFFFF},  // R8
    {16'h7FFF, 16'd16,    1'b1, 2'b10, 16'h0000},  // R8
    {16'hBEEF, 16'd0,     1'b1, 2'b01, 16'hBEEF},  // R6
    {16'hBEEF, 16'd16,    1'b0, 2'b11, 16'hBEEF},  // R7
    {16'h0001, 16'd15,    1'b0, 2'b10, 16'hFFFF},  // R4
    {16'h0001, 16'd15,    1'b1, 2'b00, 16'h0000}   // R2
  };

  // one-position-at-a-time reference
  function automatic logic [W-1:0] ref_shift(logic [W-1:0] d, logic [15:0] a,
                                             logic dr, logic [1:0] m);
    logic [W-1:0] x = d;
    int n;
    logic f;
    if (m == 2'b11) n = int'(a % 16);
    else            n = (a >= 16) ? 16 : int'(a);
    for (int k = 0; k < n; k++) begin
      if (!dr) begin
        case (m)
          2'b00: f = 1'b0;
          2'b01: f = 1'b1;
          2'b10: f = x[0];
          default: f = x[W-1];
        endcase
        x = {x[W-2:0], f};
      end else begin
        case (m)
          2'b00: f = 1'b0;
          2'b01: f = 1'b1;
          2'b10: f = x[W-1];
          default: f = x[0];
        endcase
        x = {f, x[W-1:1]};
      end
    end
    return x;
  endfunction

  task automatic apply(logic [W-1:0] d, logic [15:0] a, logic dr, logic [1:0] m);
    @(negedge clk);
    data_i = d; amt_i = a; dir_i = dr; mode_i = m;
    #2;
  endtask

  task automatic check(string req, logic [W-1:0] exp);
    n_run++;
    if (data_o !== exp) begin
      n_fail++;
      $display("FAIL %s data_o actual=%h expected=%h (d=%h a=%0d dir=%b mode=%b)",
               req, data_o, exp, data_i, amt_i, dir_i, mode_i);
    end
    n_run++;
    if (zero_o !== (exp == '0)) begin
      n_fail++;
      $display("FAIL R9 zero_o actual=%b expected=%b", zero_o, (exp == '0));
    end
  endtask

  initial begin
    // idle state: all-zero operands
    apply('0, '0, 1'b0, 2'b00);
    check("R6", 16'h0000);

    for (int i = 0; i < NV; i++) begin
      logic [VW-1:0] v = VEC[i];
      apply(v[50:35], v[34:19], v[18], v[17:16]);
      check("R1-vec", v[15:0]);
    end

    // R6: zero count in every mode and direction
    for (int m = 0; m < 4; m++) begin
      for (int dr = 0; dr < 2; dr++) begin
        apply(16'hA5C3, 16'd0, dr[0], m[1:0]);
        check("R6", 16'hA5C3);
      end
    end

    // R7: upper count bits ignored in rotate
    apply(16'h00F1, 16'hFF03, 1'b1, 2'b11);
    check("R7", ref_shift(16'h00F1, 16'd3, 1'b1, 2'b11));

    // sweep: R1 R2 R3 R4 R5 R8 against reference
    for (int di = 0; di < 2; di++) begin
      logic [W-1:0] d = di ? 16'h8E31 : 16'h3A6D;
      for (int m = 0; m < 4; m++) begin
        for (int dr = 0; dr < 2; dr++) begin
          for (int a = 0; a <= 20; a++) begin
            apply(d, 16'(a), dr[0], m[1:0]);
            case (m)
              0: check("R2", ref_shift(d, 16'(a), dr[0], 2'b00));
              1: check("R3", ref_shift(d, 16'(a), dr[0], 2'b01));
              2: check("R4", ref_shift(d, 16'(a), dr[0], 2'b10));
              default: check("R5", ref_shift(d, 16'(a), dr[0], 2'b11));
            endcase
          end
        end
      end
    end

    // R8 large counts
    apply(16'h1234, 16'hFFFF, 1'b0, 2'b01);
    check("R8", 16'hFFFF);
    apply(16'hFFFE, 16'h8000, 1'b0, 2'b10);
    check("R8", 16'h0000);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule